// File: doc/BRIEF.md
# Eight-Entry Sample FIFO with Pointer Spacing Initialization

This block is a small sample FIFO between an input data strobe and a converter-side read strobe. Both pointers advance in one clock domain through their enables. The block also places the write pointer a programmable distance from the read pointer. This keeps a fixed latency through the FIFO and stops a read and a write from landing on the same entry. The write pointer is reloaded with a phase offset in one of two ways. A relative reset waits until the read pointer is at entry 0. An absolute reset acts as soon as a long enough FRAME is seen.

A reset can come from two sources. One is a level-style request from the register side, answered by an acknowledge. The other is the FRAME input, which counts only after it has been held high for a number of write strobes that depends on the interface width. The sync mode decides how a FRAME-triggered reset behaves. In FIFO-rate mode the SYNC input also returns the read pointer to 0. Both pointers are brought out so that the surrounding logic can monitor the FIFO level.

Top module: `fifo_ptr_init`

## Requirements
- R1: Both pointers count 0 to 7 and wrap. A cycle with wr_en high stores wr_data at the current write pointer and advances it by one. A cycle with rd_en high advances the read pointer by one and, at the same edge, registers the entry the read pointer selected onto rd_data.
- R2: Every phase offset value from 0 to 7 is loaded into the write pointer exactly as given. The recommended setting is 4.
- R3: A relative reset stays armed, with the write pointer unaffected, until a cycle in which the read pointer is 0. At the edge that ends that cycle the write pointer takes the phase offset, and the reset is then disarmed.
- R4: In FIFO-rate mode (sync_mode = 2), a qualified FRAME loads the write pointer with the phase offset at the edge after qualification, whatever the read pointer holds.
- R5: A register request (rst_req rising while rst_ack is low) always arms a relative reset, in every sync mode including FIFO-rate. FRAME arms a relative reset when sync is off (sync_mode = 0 or 3) or in data-rate mode (sync_mode = 1).
- R6: In FIFO-rate mode, SYNC high clears the read pointer to 0 at the next edge and overrides rd_en. In the other modes SYNC has no effect.
- R7: FRAME qualifies once it has been high across 1 write strobe when if_width = 0 (dual-word), 2 when if_width = 1 (word), or 4 when if_width = 2 or 3 (byte). A shorter pulse causes no reset. A qualified pulse causes exactly one reset however long it stays high. Taking FRAME low clears the count.
- R8: rst_ack rises one cycle after rst_req is seen high, stays high while rst_req is held, and falls one cycle after rst_req drops.
- R9: After synchronous reset, both pointers, rd_data and rst_ack are 0 and no relative reset is armed.
- R10: A pointer load wins over a write increment in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for both pointers |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe |
| wr_data | input | DATA_W | Sample to store |
| rd_en | input | 1 | Read strobe |
| rd_data | output | DATA_W | Registered sample read out |
| frame | input | 1 | Frame marker, also a reset trigger |
| sync | input | 1 | Read pointer clear (FIFO-rate mode only) |
| sync_mode | input | 2 | 0/3 off, 1 data-rate, 2 FIFO-rate |
| if_width | input | 2 | 0 dual-word, 1 word, 2/3 byte |
| phase_off | input | PTR_W | Offset loaded into the write pointer |
| rst_req | input | 1 | Register-side reset request level |
| rst_ack | output | 1 | Acknowledge of the request |
| wr_ptr | output | PTR_W | Current write pointer |
| rd_ptr | output | PTR_W | Current read pointer |

## Verification
The assertions take sync_mode, if_width and phase_off to be static while a reset is armed or a FRAME is being counted. They also take phase_off to be stable across the edge at which a load happens. The stimulus changes these settings only between scenarios, while FRAME is low and no request is pending. The bench never raises SYNC in the same cycle as an armed relative load, so the reloaded write pointer always has a single expected value.

// File: rtl/fpi_pkg.sv
package fpi_pkg;
  localparam logic [1:0] MODE_OFF  = 2'd0;
  localparam logic [1:0] MODE_DATA = 2'd1;
  localparam logic [1:0] MODE_FIFO = 2'd2;

  localparam int QCNT_W = 3;

  // write strobes FRAME must span before it counts as a reset
  function automatic logic [QCNT_W-1:0] frame_span(input logic [1:0] width_sel);
    case (width_sel)
      2'd0:    frame_span = QCNT_W'(1);
      2'd1:    frame_span = QCNT_W'(2);
      default: frame_span = QCNT_W'(4);
    endcase
  endfunction
endpackage

// File: rtl/fpi_mem.sv
module fpi_mem #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 8,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [PTR_W-1:0]  waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              re,
  input  logic [PTR_W-1:0]  raddr,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (we) store[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst)     rdata <= '0;
    else if (re) rdata <= store[raddr];
  end
endmodule

// File: rtl/fpi_frame_qual.sv
module fpi_frame_qual
  import fpi_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       frame,
  input  logic       wr_en,
  input  logic [1:0] if_width,
  output logic       qual
);
  logic [QCNT_W-1:0] span_cnt;
  logic              fired;
  logic [QCNT_W-1:0] need;

  assign need = frame_span(if_width);

  always_ff @(posedge clk) begin
    if (rst || !frame) begin
      span_cnt <= '0;
      fired    <= 1'b0;
      qual     <= 1'b0;
    end else begin
      qual <= 1'b0;
      if (wr_en && !fired) begin
        span_cnt <= span_cnt + 1'b1;
        if (span_cnt == need - 1'b1) begin
          qual  <= 1'b1;
          fired <= 1'b1;
        end
      end
    end
  end

  AST_SINGLE_TRIGGER: assert property (@(posedge clk) disable iff (rst)
    qual |=> !qual); // R7
  AST_FRAME_LOW_NO_TRIGGER: assert property (@(posedge clk) disable iff (rst)
    !frame |=> !qual); // R7
endmodule

// File: rtl/fpi_ptr_ctl.sv
module fpi_ptr_ctl
  import fpi_pkg::*;
#(
  parameter int DEPTH  = 8,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic             rd_en,
  input  logic             sync,
  input  logic [1:0]       sync_mode,
  input  logic [PTR_W-1:0] phase_off,
  input  logic             frame_qual,
  input  logic             req_accept,
  output logic [PTR_W-1:0] wr_ptr,
  output logic [PTR_W-1:0] rd_ptr
);
  logic fifo_rate;
  logic abs_load;
  logic rel_arm;
  logic rel_load;
  logic armed;

  assign fifo_rate = (sync_mode == MODE_FIFO);
  assign abs_load  = frame_qual && fifo_rate;
  assign rel_arm   = req_accept || (frame_qual && !fifo_rate);
  assign rel_load  = armed && (rd_ptr == '0);

  always_ff @(posedge clk) begin
    if (rst)           armed <= 1'b0;
    else if (rel_arm)  armed <= 1'b1;
    else if (rel_load) armed <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst)                       wr_ptr <= '0;
    else if (abs_load || rel_load) wr_ptr <= phase_off;
    else if (wr_en)                wr_ptr <= wr_ptr + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst)                    rd_ptr <= '0;
    else if (fifo_rate && sync) rd_ptr <= '0;
    else if (rd_en)             rd_ptr <= rd_ptr + 1'b1;
  end

  AST_RD_STEP: assert property (@(posedge clk) disable iff (rst)
    (rd_en && !(fifo_rate && sync)) |=> rd_ptr == $past(rd_ptr) + 1'b1); // R1
  AST_SYNC_CLEARS_RD: assert property (@(posedge clk) disable iff (rst)
    (fifo_rate && sync) |=> rd_ptr == '0); // R6
  AST_REL_AT_ZERO: assert property (@(posedge clk) disable iff (rst)
    (armed && rd_ptr == '0) |=> wr_ptr == $past(phase_off)); // R3
  AST_ABS_IMMEDIATE: assert property (@(posedge clk) disable iff (rst)
    (frame_qual && fifo_rate) |=> wr_ptr == $past(phase_off)); // R4
  AST_WR_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!wr_en && !abs_load && !(armed && rd_ptr == '0)) |=> $stable(wr_ptr)); // R3
endmodule

// File: rtl/fifo_ptr_init.sv
module fifo_ptr_init #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 8,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rd_data,
  input  logic              frame,
  input  logic              sync,
  input  logic [1:0]        sync_mode,
  input  logic [1:0]        if_width,
  input  logic [PTR_W-1:0]  phase_off,
  input  logic              rst_req,
  output logic              rst_ack,
  output logic [PTR_W-1:0]  wr_ptr,
  output logic [PTR_W-1:0]  rd_ptr
);
  logic frame_qual;
  logic req_accept;

  // handshake: acknowledge tracks the request one cycle late
  always_ff @(posedge clk) begin
    if (rst) rst_ack <= 1'b0;
    else     rst_ack <= rst_req;
  end

  assign req_accept = rst_req && !rst_ack;

  fpi_frame_qual u_qual (
    .clk      (clk),
    .rst      (rst),
    .frame    (frame),
    .wr_en    (wr_en),
    .if_width (if_width),
    .qual     (frame_qual)
  );

  fpi_ptr_ctl #(.DEPTH(DEPTH)) u_ptr (
    .clk        (clk),
    .rst        (rst),
    .wr_en      (wr_en),
    .rd_en      (rd_en),
    .sync       (sync),
    .sync_mode  (sync_mode),
    .phase_off  (phase_off),
    .frame_qual (frame_qual),
    .req_accept (req_accept),
    .wr_ptr     (wr_ptr),
    .rd_ptr     (rd_ptr)
  );

  fpi_mem #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_mem (
    .clk   (clk),
    .rst   (rst),
    .we    (wr_en),
    .waddr (wr_ptr),
    .wdata (wr_data),
    .re    (rd_en),
    .raddr (rd_ptr),
    .rdata (rd_data)
  );

  AST_ACK_RISES: assert property (@(posedge clk) disable iff (rst)
    (rst_req && !rst_ack) |=> rst_ack); // R8
  AST_ACK_DROPS: assert property (@(posedge clk) disable iff (rst)
    (!rst_req && rst_ack) |=> !rst_ack); // R8
endmodule

// File: tb/tb_fifo_ptr_init.sv
module tb_fifo_ptr_init;
  localparam int DATA_W = 16;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              wr_en = 1'b0;
  logic [DATA_W-1:0] wr_data = '0;
  logic              rd_en = 1'b0;
  logic [DATA_W-1:0] rd_data;
  logic              frame = 1'b0;
  logic              sync = 1'b0;
  logic [1:0]        sync_mode = 2'd0;
  logic [1:0]        if_width = 2'd0;
  logic [2:0]        phase_off = 3'd4;
  logic              rst_req = 1'b0;
  logic              rst_ack;
  logic [2:0]        wr_ptr;
  logic [2:0]        rd_ptr;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  fifo_ptr_init #(.DATA_W(DATA_W), .DEPTH(8)) dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
    .rd_en(rd_en), .rd_data(rd_data), .frame(frame), .sync(sync),
    .sync_mode(sync_mode), .if_width(if_width), .phase_off(phase_off),
    .rst_req(rst_req), .rst_ack(rst_ack), .wr_ptr(wr_ptr), .rd_ptr(rd_ptr)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic t_reset();
    chk("R9", "wr_ptr", wr_ptr, 0);
    chk("R9", "rd_ptr", rd_ptr, 0);
    chk("R9", "rst_ack", rst_ack, 0);
    chk("R9", "rd_data", rd_data, 0);
  endtask

  task automatic t_wrap_data();
    for (int i = 0; i < 8; i++) begin
      wr_en = 1'b1; wr_data = DATA_W'(16'hA0 + i);
      tick();
    end
    wr_en = 1'b0;
    chk("R1", "wr_ptr wrap", wr_ptr, 0);
    for (int i = 0; i < 8; i++) begin
      rd_en = 1'b1;
      tick();
      chk("R1", "rd_data", rd_data, 16'hA0 + i);
      chk("R1", "rd_ptr", rd_ptr, (i + 1) % 8);
    end
    rd_en = 1'b0;
  endtask

  // register request in FIFO-rate mode still waits for read pointer 0
  task automatic t_reg_relative();
    sync_mode = 2'd2; phase_off = 3'd4;
    for (int i = 0; i < 5; i++) begin rd_en = 1'b1; tick(); end
    rd_en = 1'b0;
    chk("R1", "rd_ptr at 5", rd_ptr, 5);
    rst_req = 1'b1;
    tick();
    chk("R8", "ack raised", rst_ack, 1);
    for (int i = 0; i < 3; i++) tick();
    chk("R5", "no immediate load in fifo-rate", wr_ptr, 0);
    chk("R8", "ack held", rst_ack, 1);
    rst_req = 1'b0;
    tick();
    chk("R8", "ack dropped", rst_ack, 0);
    rd_en = 1'b1;
    tick(); chk("R3", "armed rd6", wr_ptr, 0);
    tick(); chk("R3", "armed rd7", wr_ptr, 0);
    tick(); chk("R3", "rd reaches 0", rd_ptr, 0);
    chk("R3", "not yet loaded", wr_ptr, 0);
    tick(); chk("R3", "loaded after rd 0", wr_ptr, 4);
    chk("R2", "offset 4", wr_ptr, 4);
    for (int i = 0; i < 8; i++) tick();
    rd_en = 1'b0;
    chk("R3", "disarmed after load", wr_ptr, 4);
    chk("R1", "rd_ptr after lap", rd_ptr, 1);
  endtask

  task automatic t_sync();
    sync_mode = 2'd2; rd_en = 1'b1; sync = 1'b1;
    tick();
    chk("R6", "sync clears over rd_en", rd_ptr, 0);
    sync = 1'b0;
    tick();
    chk("R6", "rd resumes", rd_ptr, 1);
    sync_mode = 2'd1; sync = 1'b1;
    tick();
    chk("R6", "sync ignored in data-rate", rd_ptr, 2);
    sync = 1'b0; rd_en = 1'b0;
  endtask

  task automatic t_frame_abs();
    sync_mode = 2'd2; if_width = 2'd2; phase_off = 3'd5;
    frame = 1'b1; wr_en = 1'b1;
    for (int i = 0; i < 3; i++) begin
      tick();
      chk("R7", "short byte frame", wr_ptr, (4 + i + 1) % 8);
    end
    frame = 1'b0; wr_en = 1'b0;
    tick();
    chk("R7", "no reset from short pulse", wr_ptr, 7);
    frame = 1'b1; wr_en = 1'b1;
    for (int i = 0; i < 4; i++) begin
      tick();
      chk("R7", "counting byte frame", wr_ptr, i);
    end
    tick();
    chk("R4", "absolute load", wr_ptr, 5);
    chk("R10", "load beats increment", wr_ptr, 5);
    chk("R4", "rd untouched", rd_ptr, 2);
    for (int i = 0; i < 3; i++) begin
      tick();
      chk("R7", "one reset per pulse", wr_ptr, (6 + i) % 8);
    end
    frame = 1'b0; wr_en = 1'b0;
    tick();
  endtask

  task automatic t_frame_rel_word();
    sync_mode = 2'd1; if_width = 2'd1; phase_off = 3'd6;
    frame = 1'b1; wr_en = 1'b1;
    tick(); chk("R7", "word frame 1 strobe", wr_ptr, 1);
    tick(); chk("R7", "word frame 2 strobes", wr_ptr, 2);
    frame = 1'b0; wr_en = 1'b0;
    tick(); tick();
    chk("R5", "data-rate frame is relative", wr_ptr, 2);
    rd_en = 1'b1;
    for (int i = 0; i < 6; i++) tick();
    chk("R3", "rd at 0", rd_ptr, 0);
    chk("R3", "still armed", wr_ptr, 2);
    tick();
    rd_en = 1'b0;
    chk("R3", "relative load data-rate", wr_ptr, 6);
  endtask

  task automatic t_frame_rel_off();
    sync_mode = 2'd0; if_width = 2'd0; phase_off = 3'd0;
    rd_en = 1'b1;
    for (int i = 0; i < 7; i++) tick();
    rd_en = 1'b0;
    chk("R1", "rd back to 0", rd_ptr, 0);
    frame = 1'b1; wr_en = 1'b1;
    tick(); chk("R7", "dual-word 1 strobe", wr_ptr, 7);
    frame = 1'b0; wr_en = 1'b0;
    tick(); chk("R5", "off mode arming", wr_ptr, 7);
    tick(); chk("R2", "offset 0 loaded", wr_ptr, 0);
  endtask

  initial begin
    repeat (3) tick();
    rst = 1'b0;
    tick();
    t_reset();
    t_wrap_data();
    t_reg_relative();
    t_sync();
    t_frame_abs();
    t_frame_rel_word();
    t_frame_rel_off();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule